// File: doc/BRIEF.md
# Display Memory Write Packet Decoder

This block sits behind a serial receiver and turns its byte stream into write operations for an on-screen-display character memory. The memory has two planes, one holding 9-bit character indices and one holding attribute bytes. Every write names a row, a column, a plane and a 9-bit value. The receiver supplies a strobe for each received byte, together with one-cycle markers for the start and the end of a packet.

Flag bits inside each byte decide whether it is a row byte or a column byte. A row byte sets the row and picks the plane. A column byte sets the column and the ninth value bit, and it also chooses how the bytes that follow are used:
- A single data byte that is followed by another address. If that address is a row byte, this is the fully addressed style. If it is a column byte, this is the same-row style.
- An open-ended run of data bytes written to consecutive locations.

After the run mode is entered, the decoder stays in it until the packet ends. The serial line protocol and the memory itself are outside this block.

Top module: `osd_pkt_decoder`

## Requirements
- R1: While reset is active, and after reset is released, `wr_en` is low. The decoder starts idle, so no write can occur before the first packet-start marker.
- R2: While a row byte is awaited, a byte with bit7 = 1 loads the row from bits 4..0 and the plane from bit5 (0 = index plane, 1 = attribute plane) and issues no write. A byte with bit7 = 0 in that slot is ignored.
- R3: In an address slot, meaning after a row byte or after a single data byte, bit7 = 1 makes the byte a new row byte. Bit7 = 0 makes it a column byte: the column comes from bits 4..0, the ninth value bit from bit5, and bit6 = 1 selects run mode while bit6 = 0 selects single-data mode. Address bytes never write.
- R4: Every write carries the data byte in value bits 7..0. On the index plane, value bit 8 is the bit5 captured from the most recent column byte. On the attribute plane, value bit 8 is 0.
- R5: In single-data mode, the next byte of any value is written once at the current row and column. The decoder then returns to an address slot.
- R6: In run mode, each data byte is written one column after the previous one. After column 31, the column wraps to 0 and the row advances by one. After row 31, the row wraps to 0.
- R7: In run mode, every byte is treated as data, including bytes with bit7 = 1, until the packet-end marker.
- R8: A packet-start marker makes the next byte be read as a row byte. A packet-end marker returns the decoder to idle and drops any partly received address. A byte presented in the same cycle as either marker is dropped, and the end marker wins over the start marker.
- R9: While idle, received bytes cause no write.
- R10: `wr_en` is a one-cycle pulse in the cycle after the accepted data byte, with exactly one pulse per data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| byte_vld | input | 1 | A received byte is present on `byte_in` |
| byte_in | input | 8 | Received byte |
| pkt_start | input | 1 | One-cycle marker: packet begins |
| pkt_end | input | 1 | One-cycle marker: packet ends |
| wr_en | output | 1 | Write strobe, one cycle |
| wr_row | output | 5 | Target row |
| wr_col | output | 5 | Target column |
| wr_attr | output | 1 | 1 = attribute plane, 0 = index plane |
| wr_data | output | 9 | Value to write |

## Verification
The assertions assume three things about the inputs:
- The packet markers arrive one cycle apart from the byte strobes.
- Each packet begins with a start marker and ends with an end marker.
- Row and column fields are five bits wide, so a run step is a plain increment of the concatenated row and column.

The stimulus never raises a marker in the same cycle as `byte_vld`. Each generated packet is framed by a start marker and an end marker, and the stray bytes sent between packets still fall into the idle case the assertions cover. The packet contents are drawn at random from templates for the fully addressed style, the same-row style, run mode, and unstructured bytes. Directed packets are added for the row and column wrap, for a switch from single-data mode to run mode, and for an address that is cut off by an end marker.

// File: rtl/osd_pkt_pkg.sv
package osd_pkt_pkg;

  // Decoder phases; the encoding is only used inside the block and its checker.
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,  // between packets, everything dropped
    ST_ROW    = 3'd1,  // packet opened, only a row byte accepted
    ST_ADDR   = 3'd2,  // row or column byte accepted
    ST_DATA   = 3'd3,  // exactly one data byte expected
    ST_STREAM = 3'd4   // every byte is data, address advances
  } dec_state_e;

  // Flag positions inside a received byte. A neighbour (the sender) encodes
  // these, so the positions are fixed behaviour.
  localparam int unsigned KIND_BIT  = 7;  // 1: row byte, 0: column byte
  localparam int unsigned RUN_BIT   = 6;  // column byte: 1 selects run mode
  localparam int unsigned PLANE_BIT = 5;  // row byte: 1 selects attribute plane
  localparam int unsigned BANK_BIT  = 5;  // column byte: ninth value bit

endpackage

// File: rtl/osd_byte_classify.sv
// Splits a received byte into its flag bits and address fields.
module osd_byte_classify
  import osd_pkt_pkg::*;
#(
  parameter int unsigned ROW_W  = 5,
  parameter int unsigned COL_W  = 5,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] byte_i,
  output logic              is_row_o,
  output logic              is_run_o,
  output logic              plane_o,
  output logic              bank_o,
  output logic [ROW_W-1:0]  row_f_o,
  output logic [COL_W-1:0]  col_f_o
);

  localparam int unsigned FIELD_W = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic [FIELD_W-1:0] field;

  always_comb begin
    field    = byte_i[FIELD_W-1:0];
    is_row_o = byte_i[KIND_BIT];
    is_run_o = byte_i[RUN_BIT];
    plane_o  = byte_i[PLANE_BIT];
    bank_o   = byte_i[BANK_BIT];
    row_f_o  = field[ROW_W-1:0];
    col_f_o  = field[COL_W-1:0];
  end

endmodule

// File: rtl/osd_pkt_fsm.sv
// Phase control: decides for each accepted byte whether it loads a row,
// loads a column, or produces a write, and whether the address then steps.
module osd_pkt_fsm
  import osd_pkt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_vld,
  input  logic       is_row,
  input  logic       is_run,
  input  logic       pkt_start,
  input  logic       pkt_end,
  output logic       ld_row_o,
  output logic       ld_col_o,
  output logic       fire_o,
  output logic       step_o,
  output dec_state_e st_o
);

  dec_state_e st_q, st_d;
  logic       take;

  // A byte counts only when no packet marker shares its cycle.
  assign take = byte_vld & ~pkt_start & ~pkt_end;

  always_comb begin
    st_d     = st_q;
    ld_row_o = 1'b0;
    ld_col_o = 1'b0;
    fire_o   = 1'b0;
    step_o   = 1'b0;
    if (pkt_end) begin
      st_d = ST_IDLE;
    end else if (pkt_start) begin
      st_d = ST_ROW;
    end else if (take) begin
      unique case (st_q)
        ST_IDLE: begin
          st_d = ST_IDLE;
        end
        ST_ROW: begin
          if (is_row) begin
            ld_row_o = 1'b1;
            st_d     = ST_ADDR;
          end
        end
        ST_ADDR: begin
          if (is_row) begin
            ld_row_o = 1'b1;
            st_d     = ST_ADDR;
          end else begin
            ld_col_o = 1'b1;
            st_d     = is_run ? ST_STREAM : ST_DATA;
          end
        end
        ST_DATA: begin
          fire_o = 1'b1;
          st_d   = ST_ADDR;
        end
        ST_STREAM: begin
          fire_o = 1'b1;
          step_o = 1'b1;
          st_d   = ST_STREAM;
        end
        default: begin
          st_d = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  assign st_o = st_q;

endmodule

// File: rtl/osd_addr_track.sv
// Holds the current row, column, plane and ninth value bit; loads them from
// address bytes and advances the location during run mode.
module osd_addr_track #(
  parameter int unsigned ROW_W = 5,
  parameter int unsigned COL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_row,
  input  logic             ld_col,
  input  logic             step,
  input  logic [ROW_W-1:0] row_f,
  input  logic [COL_W-1:0] col_f,
  input  logic             plane_f,
  input  logic             bank_f,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic             attr_o,
  output logic             bank_o
);

  localparam logic [COL_W-1:0] COL_LAST = {COL_W{1'b1}};
  localparam logic [ROW_W-1:0] ROW_ONE  = {{(ROW_W-1){1'b0}}, 1'b1};
  localparam logic [COL_W-1:0] COL_ONE  = {{(COL_W-1){1'b0}}, 1'b1};

  logic [ROW_W-1:0] row_q, row_d;
  logic [COL_W-1:0] col_q, col_d;
  logic             attr_q, attr_d;
  logic             bank_q, bank_d;
  logic             row_en, col_en;

  // Clock enables for each field.
  assign row_en = ld_row | (step & (col_q == COL_LAST));
  assign col_en = ld_col | step;

  always_comb begin
    row_d  = row_q;
    col_d  = col_q;
    attr_d = attr_q;
    bank_d = bank_q;
    if (ld_row) begin
      row_d  = row_f;
      attr_d = plane_f;
    end else if (step && (col_q == COL_LAST)) begin
      row_d = row_q + ROW_ONE;
    end
    if (ld_col) begin
      col_d  = col_f;
      bank_d = bank_f;
    end else if (step) begin
      col_d = (col_q == COL_LAST) ? '0 : (col_q + COL_ONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      attr_q <= 1'b0;
    end else if (row_en) begin
      row_q  <= row_d;
      attr_q <= attr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      bank_q <= 1'b0;
    end else if (col_en) begin
      col_q  <= col_d;
      bank_q <= bank_d;
    end
  end

  assign row_o  = row_q;
  assign col_o  = col_q;
  assign attr_o = attr_q;
  assign bank_o = bank_q;

endmodule

// File: rtl/osd_wr_stage.sv
// Output register: one pulse per data byte, payload captured with it.
module osd_wr_stage #(
  parameter int unsigned ROW_W  = 5,
  parameter int unsigned COL_W  = 5,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              attr_i,
  input  logic              bank_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              wr_en_o,
  output logic [ROW_W-1:0]  wr_row_o,
  output logic [COL_W-1:0]  wr_col_o,
  output logic              wr_attr_o,
  output logic [BYTE_W:0]   wr_data_o
);

  localparam int unsigned VAL_W = BYTE_W + 1;

  logic [VAL_W-1:0] val_d;
  logic             en_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             attr_q;
  logic [VAL_W-1:0] val_q;

  // The ninth bit only exists on the index plane.
  always_comb begin
    val_d = {(bank_i & ~attr_i), byte_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else begin
      en_q <= fire;
    end
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      row_q  <= row_i;
      col_q  <= col_i;
      attr_q <= attr_i;
      val_q  <= val_d;
    end
  end

  assign wr_en_o   = en_q;
  assign wr_row_o  = row_q;
  assign wr_col_o  = col_q;
  assign wr_attr_o = attr_q;
  assign wr_data_o = val_q;

endmodule

// File: rtl/osd_pkt_decoder.sv
// Top level: reset release synchronizer, byte classifier, phase control,
// address tracker and write register.
module osd_pkt_decoder
  import osd_pkt_pkg::*;
#(
  parameter int unsigned ROW_W  = 5,
  parameter int unsigned COL_W  = 5,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              pkt_start,
  input  logic              pkt_end,
  output logic              wr_en,
  output logic [ROW_W-1:0]  wr_row,
  output logic [COL_W-1:0]  wr_col,
  output logic              wr_attr,
  output logic [BYTE_W:0]   wr_data
);

  // Reset: asserted at once, removed on a clock edge.
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  logic             is_row, is_run, plane_f, bank_f;
  logic [ROW_W-1:0] row_f, cur_row;
  logic [COL_W-1:0] col_f, cur_col;
  logic             cur_attr, cur_bank;
  logic             ld_row, ld_col, fire, step;
  dec_state_e       st_q;

  osd_byte_classify #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .BYTE_W(BYTE_W)
  ) u_classify (
    .byte_i  (byte_in),
    .is_row_o(is_row),
    .is_run_o(is_run),
    .plane_o (plane_f),
    .bank_o  (bank_f),
    .row_f_o (row_f),
    .col_f_o (col_f)
  );

  osd_pkt_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .byte_vld (byte_vld),
    .is_row   (is_row),
    .is_run   (is_run),
    .pkt_start(pkt_start),
    .pkt_end  (pkt_end),
    .ld_row_o (ld_row),
    .ld_col_o (ld_col),
    .fire_o   (fire),
    .step_o   (step),
    .st_o     (st_q)
  );

  osd_addr_track #(
    .ROW_W(ROW_W),
    .COL_W(COL_W)
  ) u_track (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .ld_row (ld_row),
    .ld_col (ld_col),
    .step   (step),
    .row_f  (row_f),
    .col_f  (col_f),
    .plane_f(plane_f),
    .bank_f (bank_f),
    .row_o  (cur_row),
    .col_o  (cur_col),
    .attr_o (cur_attr),
    .bank_o (cur_bank)
  );

  osd_wr_stage #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .BYTE_W(BYTE_W)
  ) u_wr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .fire     (fire),
    .row_i    (cur_row),
    .col_i    (cur_col),
    .attr_i   (cur_attr),
    .bank_i   (cur_bank),
    .byte_i   (byte_in),
    .wr_en_o  (wr_en),
    .wr_row_o (wr_row),
    .wr_col_o (wr_col),
    .wr_attr_o(wr_attr),
    .wr_data_o(wr_data)
  );

endmodule

// File: rtl/osd_pkt_decoder_chk.sv
// Property checker attached to the decoder top.
module osd_pkt_decoder_chk
  import osd_pkt_pkg::*;
#(
  parameter int unsigned ROW_W  = 5,
  parameter int unsigned COL_W  = 5,
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_vld,
  input logic              pkt_start,
  input logic              pkt_end,
  input dec_state_e        st,
  input logic              wr_en,
  input logic [ROW_W-1:0]  wr_row,
  input logic [COL_W-1:0]  wr_col,
  input logic              wr_attr,
  input logic [BYTE_W:0]   wr_data
);

  localparam int unsigned LIN_W = ROW_W + COL_W;
  localparam logic [LIN_W-1:0] LIN_ONE = {{(LIN_W-1){1'b0}}, 1'b1};

  // Remembers the location of the previous run-mode write.
  logic [LIN_W-1:0] prev_lin;
  logic             prev_ok;
  logic [LIN_W-1:0] lin_next;

  assign lin_next = prev_lin + LIN_ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_lin <= '0;
      prev_ok  <= 1'b0;
    end else if (st != ST_STREAM) begin
      prev_ok <= 1'b0;
    end else if (wr_en) begin
      prev_lin <= {wr_row, wr_col};
      prev_ok  <= 1'b1;
    end
  end

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |=> !wr_en);  // R9

  AST_ADDR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ROW || st == ST_ADDR) |=> !wr_en);  // R3

  AST_ATTR_NINTH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_attr) |-> !wr_data[BYTE_W]);  // R4

  AST_RUN_ALL_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !pkt_start && !pkt_end && st == ST_STREAM) |=> wr_en);  // R7

  AST_RUN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && prev_ok && st == ST_STREAM) |-> ({wr_row, wr_col} == lin_next));  // R6

  AST_END_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |=> (st == ST_IDLE));  // R8

  AST_START_TO_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_start && !pkt_end) |=> (st == ST_ROW));  // R8

  AST_WR_FROM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(byte_vld));  // R10

  AST_DATA_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA && byte_vld && !pkt_start && !pkt_end) |=> (st == ST_ADDR));  // R5

endmodule

bind osd_pkt_decoder osd_pkt_decoder_chk #(
  .ROW_W (ROW_W),
  .COL_W (COL_W),
  .BYTE_W(BYTE_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .byte_vld (byte_vld),
  .pkt_start(pkt_start),
  .pkt_end  (pkt_end),
  .st       (st_q),
  .wr_en    (wr_en),
  .wr_row   (wr_row),
  .wr_col   (wr_col),
  .wr_attr  (wr_attr),
  .wr_data  (wr_data)
);

// File: tb/osd_pkt_decoder_tb.sv
module osd_pkt_decoder_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       byte_vld;
  logic [7:0] byte_in;
  logic       pkt_start;
  logic       pkt_end;
  logic       wr_en;
  logic [4:0] wr_row;
  logic [4:0] wr_col;
  logic       wr_attr;
  logic [8:0] wr_data;

  int  total;
  int  bad;
  bit  done;

  // Expected-behaviour model state: 0 idle, 1 row, 2 address, 3 data, 4 run.
  int       m_st;
  logic [4:0] m_row;
  logic [4:0] m_col;
  logic       m_attr;
  logic       m_d8;

  osd_pkt_decoder u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_vld (byte_vld),
    .byte_in  (byte_in),
    .pkt_start(pkt_start),
    .pkt_end  (pkt_end),
    .wr_en    (wr_en),
    .wr_row   (wr_row),
    .wr_col   (wr_col),
    .wr_attr  (wr_attr),
    .wr_data  (wr_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic check_out(input string req, input logic e_en, input logic [4:0] er,
                           input logic [4:0] ec, input logic ea, input logic [8:0] ed);
    total++;
    if (wr_en !== e_en ||
        (e_en && (wr_row !== er || wr_col !== ec || wr_attr !== ea || wr_data !== ed))) begin
      bad++;
      $display("FAIL %s: got en=%0b row=%0d col=%0d attr=%0b data=%h, expected en=%0b row=%0d col=%0d attr=%0b data=%h",
               req, wr_en, wr_row, wr_col, wr_attr, wr_data, e_en, er, ec, ea, ed);
    end
  endtask

  // Drive one byte for one cycle, predict, then check the registered output.
  task automatic send(input logic [7:0] b, input string req_o);
    logic       e_en;
    logic [4:0] e_row, e_col;
    logic       e_attr;
    logic [8:0] e_dat;
    string      req;
    e_en   = 1'b0;
    e_row  = m_row;
    e_col  = m_col;
    e_attr = m_attr;
    e_dat  = {(m_attr ? 1'b0 : m_d8), b};
    req    = "R9";
    case (m_st)
      1: begin
        req = "R2";
        if (b[7]) begin m_row = b[4:0]; m_attr = b[5]; m_st = 2; end
      end
      2: begin
        req = "R3";
        if (b[7]) begin
          m_row = b[4:0]; m_attr = b[5];
        end else begin
          m_col = b[4:0]; m_d8 = b[5]; m_st = b[6] ? 4 : 3;
        end
      end
      3: begin req = "R5 R4"; e_en = 1'b1; m_st = 2; end
      4: begin
        req = b[7] ? "R7 R4" : "R6 R4";
        e_en = 1'b1;
        {m_row, m_col} = {m_row, m_col} + 10'd1;
      end
      default: req = "R9";
    endcase
    if (req_o != "") req = req_o;
    byte_vld = 1'b1;
    byte_in  = b;
    @(negedge clk);
    byte_vld = 1'b0;
    byte_in  = 8'h00;
    check_out(req, e_en, e_row, e_col, e_attr, e_dat);
  endtask

  task automatic mark(input bit is_start);
    if (is_start) pkt_start = 1'b1; else pkt_end = 1'b1;
    @(negedge clk);
    pkt_start = 1'b0;
    pkt_end   = 1'b0;
    m_st = is_start ? 1 : 0;
    check_out("R8", 1'b0, 5'd0, 5'd0, 1'b0, 9'd0);
  endtask

  function automatic logic [7:0] rnd_row();
    return 8'h80 | 8'($urandom & 32'h3F);
  endfunction

  function automatic logic [7:0] rnd_col(input bit run);
    return (8'($urandom & 32'h3F)) | (run ? 8'h40 : 8'h00);
  endfunction

  // Watchdog: a hung run counts as a failure and still prints the summary.
  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++;
      $display("FAIL R10: watchdog expired, got no finish, expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; done = 1'b0;
    m_st = 0; m_row = '0; m_col = '0; m_attr = 1'b0; m_d8 = 1'b0;
    rst_n = 1'b0; byte_vld = 1'b0; byte_in = 8'h00; pkt_start = 1'b0; pkt_end = 1'b0;
    void'($urandom(32'd20240517));

    // R1: quiet during and after reset.
    repeat (4) begin
      @(negedge clk);
      check_out("R1", 1'b0, 5'd0, 5'd0, 1'b0, 9'd0);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_out("R1", 1'b0, 5'd0, 5'd0, 1'b0, 9'd0);

    // R9: bytes before any packet are dropped.
    send(8'h81, "R9"); send(8'h05, "R9"); send(8'h33, "R9");

    // R2: column-looking byte while a row is awaited is ignored.
    mark(1);
    send(8'h15, "R2");
    send(8'hA5, "R2");            // row 5, attribute plane
    send(8'h23, "R3");            // column 3, bank bit set, single data
    send(8'hFF, "R4");            // attribute plane: ninth bit 0
    send(8'h07, "R3");            // same row, column 7, bank 0
    send(8'h80, "R5");            // data with bit7 set is still data
    send(8'h82, "R3");            // new row 2, index plane
    send(8'h29, "R3");            // column 9, bank 1
    send(8'h5A, "R4");            // index plane: ninth bit 1
    // switch from single data to run mode
    send(8'h70, "R3");            // run, bank 1, column 16
    send(8'h01, ""); send(8'hC4, "R7"); send(8'h9F, "R7");
    mark(0);

    // R6: column and row wrap at the far corner.
    mark(1);
    send(8'h9F, "");              // row 31
    send(8'h7E, "");              // run, bank 1, column 30
    send(8'hA1, "R6"); send(8'h82, "R6"); send(8'h33, "R6"); send(8'h44, "R6");
    mark(0);

    // R8: partial address dropped by the end marker.
    mark(1);
    send(8'h83, "R8");
    mark(0);
    send(8'h12, "R8");
    mark(1);
    send(8'h05, "R8");            // column byte without a row: ignored
    send(8'h84, ""); send(8'h02, ""); send(8'h11, "R8");
    mark(0);

    // Long run covers every location once.
    mark(1);
    send(rnd_row(), ""); send(rnd_col(1'b1), "");
    for (int i = 0; i < 1030; i++) send(8'($urandom), "");
    mark(0);

    // Random packets of every style.
    for (int p = 0; p < 150; p++) begin
      int sty;
      sty = int'($urandom % 4);
      if (($urandom % 5) == 0) send(8'($urandom), "");
      mark(1);
      case (sty)
        0: for (int k = 0; k < 1 + int'($urandom % 6); k++) begin
             send(rnd_row(), ""); send(rnd_col(1'b0), ""); send(8'($urandom), "");
           end
        1: begin
             send(rnd_row(), "");
             for (int k = 0; k < 1 + int'($urandom % 8); k++) begin
               if (($urandom % 4) == 0) send(rnd_row(), "");
               send(rnd_col(1'b0), ""); send(8'($urandom), "");
             end
           end
        2: begin
             send(rnd_row(), "");
             if ($urandom % 2) begin send(rnd_col(1'b0), ""); send(8'($urandom), ""); end
             send(rnd_col(1'b1), "");
             for (int k = 0; k < 5 + int'($urandom % 60); k++) send(8'($urandom), "");
           end
        default: for (int k = 0; k < 5 + int'($urandom % 25); k++) send(8'($urandom), "");
      endcase
      mark(0);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule